// File: doc/BRIEF.md
# Per-User Post-Equalization SINR Estimator

This block sits between the per-subcarrier preprocessing of a multi-user uplink receiver and the soft-output (LLR) stage. For every user it produces three per-block statistics: the effective time-domain channel gain `mu`, the residual noise-plus-interference variance `nu2`, and the post-equalization SINR `rho2`. It works from two diagonal quantities for each subcarrier. One is the diagonal Gram entry `g`. The other is the reciprocal `dinv` of the regularized diagonal entry. Both come from the one-term (diagonal-only) inverse approximation. That approximation is used whatever number of series terms the equalizer itself runs, so the exact post-equalization statistics are never needed.

Beats arrive on a valid/ready stream. Each beat carries one subcarrier's `(g, dinv)` pair and the index of the user it belongs to. Beats of different users may be interleaved freely. The beat flagged as last closes the block. After that beat the block stops accepting input (`in_ready` low). It then emits one result per user, in ascending user order, on a valid/ready output stream. A result that has been offered stays offered with unchanged fields until the consumer takes it. Once the last user's result is taken, input opens again and the next beat starts a fresh block. The symbol energy `es` and the reciprocal block length `recip_len` are plain inputs. They must hold steady from the closing beat until the last result has left.

Top module: `sinr_est`

## Requirements
- R1: During reset and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Each accepted beat adds `term = (g * dinv) >> DINV_FRAC` to the running sum `S` of its user. A user's gain is `mu = (S * recip_len) >> RL_FRAC`, where `recip_len` is an unsigned value with `RL_FRAC` fraction bits.
- R3: The first beat of a block, which is the first beat after reset or after a closing beat, starts every user's sum from zero. A user with no beats in a block reports `mu = 0`, `nu2 = NU_FLOOR` and `rho2 = 0`. A beat whose user index is at or above `NUM_USERS` is accepted but adds to no sum.
- R4: `nu2 = es*S - es*mu*mu`. When that difference is negative or below `NU_FLOOR`, `nu2` is `NU_FLOOR`.
- R5: `rho2 = floor((mu*mu << RHO_FRAC) / nu2)`. A quotient that does not fit in `RHO_W` bits gives all ones.
- R6: After the closing beat, exactly one result per user is emitted, in the order 0, 1, …, `NUM_USERS-1`. Each result carries its index on `out_user`.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1 with all result fields unchanged.
- R8: `in_ready` is 0 from the cycle after the closing beat is accepted until the last result of the block is accepted. No beat is taken while `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_user | input | USER_W | User index of the beat |
| in_g | input | G_W | Diagonal Gram entry, unsigned |
| in_dinv | input | DINV_W | Diagonal reciprocal, unsigned, DINV_FRAC fraction bits |
| in_last | input | 1 | Beat closes the block |
| es | input | ES_W | Symbol energy, unsigned integer |
| recip_len | input | RL_W | 1/L, unsigned, RL_FRAC fraction bits |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_user | output | USER_W | User index of the result |
| out_mu | output | ACC_W | Effective gain |
| out_nu2 | output | NU_W | Floored noise-plus-interference variance |
| out_rho2 | output | RHO_W | Saturated SINR, RHO_FRAC fraction bits |

## Verification
The bench builds the block with its defaults. Three users on a two-bit index leave index 3 free, so the ignored-index case can be driven. A 12-bit fractional `dinv` lets small Gram values produce unfloored variances, while large ones push `es*mu*mu` past `es*S`. Together with `RHO_FRAC = 4` and a floor of 1, this makes both the variance floor and the SINR saturation reachable within a few subcarriers. `MAX_L = 64` keeps the block lengths short, including the single-subcarrier block where `recip_len` caps at 65535. Output back-pressure is randomized throughout.

// File: rtl/sinr_pkg.sv
`timescale 1ns/1ps
package sinr_pkg;
  // Control phases of the estimator
  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,  // accepting subcarrier beats
    PH_STATS   = 2'd1,  // forming mu / nu2 for the selected user
    PH_DIV     = 2'd2,  // sequential SINR division
    PH_OUT     = 2'd3   // offering the result downstream
  } phase_e;
endpackage

// File: rtl/sinr_accum.sv
`timescale 1ns/1ps
// Per-user running sums of g * dinv
module sinr_accum #(
  parameter int NUM_USERS = 3,
  parameter int USER_W    = 2,
  parameter int G_W       = 12,
  parameter int DINV_W    = 12,
  parameter int DINV_FRAC = 12,
  parameter int ACC_W     = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              fresh,
  input  logic [USER_W-1:0] user,
  input  logic [G_W-1:0]    g,
  input  logic [DINV_W-1:0] dinv,
  output logic [ACC_W-1:0]  sums [NUM_USERS]
);
  localparam int PROD_W = G_W + DINV_W;

  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  term;

  assign prod = PROD_W'(g) * PROD_W'(dinv);
  assign term = ACC_W'(prod >> DINV_FRAC);

  for (genvar i = 0; i < NUM_USERS; i++) begin : g_user
    logic hit;
    assign hit = (user == USER_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sums[i] <= '0;
      end else if (take) begin
        if (fresh)    sums[i] <= hit ? term : '0;
        else if (hit) sums[i] <= sums[i] + term;
      end
    end
  end
endmodule

// File: rtl/sinr_stats.sv
`timescale 1ns/1ps
// Gain, floored variance and SINR numerator from one user's sum
module sinr_stats #(
  parameter int ACC_W    = 19,
  parameter int RL_W     = 16,
  parameter int RL_FRAC  = 16,
  parameter int ES_W     = 8,
  parameter int RHO_FRAC = 4,
  parameter int NU_FLOOR = 1,
  parameter int NU_W     = ES_W + 2*ACC_W,
  parameter int NUM_W    = 2*ACC_W + RHO_FRAC
) (
  input  logic [ACC_W-1:0] sum,
  input  logic [RL_W-1:0]  recip,
  input  logic [ES_W-1:0]  es,
  output logic [ACC_W-1:0] mu,
  output logic [NU_W-1:0]  nu2,
  output logic [NUM_W-1:0] num
);
  localparam int MP_W = ACC_W + RL_W;
  localparam int SQ_W = 2*ACC_W;

  logic [MP_W-1:0] mprod;
  logic [SQ_W-1:0] musq;
  logic [NU_W-1:0] sig_e, int_e, diff;
  logic            above;

  assign mprod = MP_W'(sum) * MP_W'(recip);
  assign mu    = ACC_W'(mprod >> RL_FRAC);
  assign musq  = SQ_W'(mu) * SQ_W'(mu);
  assign sig_e = NU_W'(es) * NU_W'(sum);
  assign int_e = NU_W'(es) * NU_W'(musq);
  assign diff  = sig_e - int_e;
  assign above = (sig_e > int_e) && (diff >= NU_W'(NU_FLOOR));
  assign nu2   = above ? diff : NU_W'(NU_FLOOR);
  assign num   = NUM_W'(musq) << RHO_FRAC;
endmodule

// File: rtl/sinr_divider.sv
`timescale 1ns/1ps
// Restoring unsigned divider, one quotient bit per cycle, saturating result
module sinr_divider #(
  parameter int N_W = 42,
  parameter int D_W = 46,
  parameter int Q_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic           done,
  output logic [Q_W-1:0] quo
);
  localparam int CNT_W = (N_W > 1) ? $clog2(N_W) : 1;

  logic [N_W-1:0]   nreg, q;
  logic [D_W-1:0]   dreg, rem;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [D_W:0]     rem_sh, rem_sub;
  logic             fits;

  assign rem_sh  = {rem, nreg[N_W-1]};
  assign rem_sub = rem_sh - {1'b0, dreg};
  assign fits    = (rem_sh >= {1'b0, dreg});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nreg <= '0; q <= '0; dreg <= '0; rem <= '0;
      cnt  <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        nreg <= num;
        dreg <= den;
        rem  <= '0;
        q    <= '0;
        cnt  <= CNT_W'(N_W - 1);
        run  <= 1'b1;
      end else if (run) begin
        rem  <= fits ? rem_sub[D_W-1:0] : rem_sh[D_W-1:0];
        q    <= {q[N_W-2:0], fits};
        nreg <= nreg << 1;
        if (cnt == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  if (N_W > Q_W) begin : g_sat
    assign quo = (|q[N_W-1:Q_W]) ? {Q_W{1'b1}} : q[Q_W-1:0];
  end else begin : g_nosat
    assign quo = Q_W'(q);
  end
endmodule

// File: rtl/sinr_est.sv
`timescale 1ns/1ps
// Per-user post-equalization SINR estimator (top)
module sinr_est
  import sinr_pkg::*;
#(
  parameter int NUM_USERS = 3,
  parameter int G_W       = 12,
  parameter int DINV_W    = 12,
  parameter int DINV_FRAC = 12,
  parameter int MAX_L     = 64,
  parameter int RL_W      = 16,
  parameter int RL_FRAC   = 16,
  parameter int ES_W      = 8,
  parameter int RHO_FRAC  = 4,
  parameter int RHO_W     = 16,
  parameter int NU_FLOOR  = 1,
  localparam int USER_W   = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1,
  localparam int LEN_W    = $clog2(MAX_L + 1),
  localparam int TERM_W   = G_W + DINV_W - DINV_FRAC,
  localparam int ACC_W    = TERM_W + LEN_W,
  localparam int NU_W     = ES_W + 2*ACC_W,
  localparam int NUM_W    = 2*ACC_W + RHO_FRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [USER_W-1:0] in_user,
  input  logic [G_W-1:0]    in_g,
  input  logic [DINV_W-1:0] in_dinv,
  input  logic              in_last,
  input  logic [ES_W-1:0]   es,
  input  logic [RL_W-1:0]   recip_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [USER_W-1:0] out_user,
  output logic [ACC_W-1:0]  out_mu,
  output logic [NU_W-1:0]   out_nu2,
  output logic [RHO_W-1:0]  out_rho2
);
  phase_e            ph;
  logic [USER_W-1:0] u_sel;
  logic              fresh;
  logic              take;
  logic [ACC_W-1:0]  sums [NUM_USERS];
  logic [ACC_W-1:0]  sum_sel;
  logic [ACC_W-1:0]  mu_c, mu_q;
  logic [NU_W-1:0]   nu2_c, nu2_q;
  logic [NUM_W-1:0]  num_c, num_q;
  logic              div_start, div_done;
  logic [RHO_W-1:0]  quo, rho_q;

  assign in_ready = (ph == PH_COLLECT);
  assign take     = in_valid && in_ready;

  sinr_accum #(
    .NUM_USERS(NUM_USERS), .USER_W(USER_W), .G_W(G_W), .DINV_W(DINV_W),
    .DINV_FRAC(DINV_FRAC), .ACC_W(ACC_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .take(take), .fresh(fresh),
    .user(in_user), .g(in_g), .dinv(in_dinv), .sums(sums)
  );

  always_comb begin
    sum_sel = '0;
    for (int i = 0; i < NUM_USERS; i++)
      if (u_sel == USER_W'(i)) sum_sel = sums[i];
  end

  sinr_stats #(
    .ACC_W(ACC_W), .RL_W(RL_W), .RL_FRAC(RL_FRAC), .ES_W(ES_W),
    .RHO_FRAC(RHO_FRAC), .NU_FLOOR(NU_FLOOR), .NU_W(NU_W), .NUM_W(NUM_W)
  ) u_stats (
    .sum(sum_sel), .recip(recip_len), .es(es),
    .mu(mu_c), .nu2(nu2_c), .num(num_c)
  );

  sinr_divider #(.N_W(NUM_W), .D_W(NU_W), .Q_W(RHO_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(num_q), .den(nu2_q), .done(div_done), .quo(quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_COLLECT;
      u_sel     <= '0;
      fresh     <= 1'b1;
      mu_q      <= '0;
      nu2_q     <= '0;
      num_q     <= '0;
      rho_q     <= '0;
      div_start <= 1'b0;
    end else begin
      div_start <= 1'b0;
      unique case (ph)
        PH_COLLECT: if (take) begin
          fresh <= in_last;
          if (in_last) begin
            ph    <= PH_STATS;
            u_sel <= '0;
          end
        end
        PH_STATS: begin
          mu_q      <= mu_c;
          nu2_q     <= nu2_c;
          num_q     <= num_c;
          div_start <= 1'b1;
          ph        <= PH_DIV;
        end
        PH_DIV: if (div_done) begin
          rho_q <= quo;
          ph    <= PH_OUT;
        end
        PH_OUT: if (out_ready) begin
          if (u_sel == USER_W'(NUM_USERS - 1)) begin
            ph <= PH_COLLECT;
          end else begin
            u_sel <= u_sel + 1'b1;
            ph    <= PH_STATS;
          end
        end
        default: ph <= PH_COLLECT;
      endcase
    end
  end

  assign out_valid = (ph == PH_OUT);
  assign out_user  = u_sel;
  assign out_mu    = mu_q;
  assign out_nu2   = nu2_q;
  assign out_rho2  = rho_q;
endmodule

// File: rtl/sinr_est_chk.sv
`timescale 1ns/1ps
module sinr_est_chk #(
  parameter int NUM_USERS = 3,
  parameter int USER_W    = 2,
  parameter int ACC_W     = 19,
  parameter int NU_W      = 46,
  parameter int RHO_W     = 16,
  parameter int NU_FLOOR  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [USER_W-1:0] out_user,
  input logic [ACC_W-1:0]  out_mu,
  input logic [NU_W-1:0]   out_nu2,
  input logic [RHO_W-1:0]  out_rho2
);
  logic [USER_W-1:0] exp_user;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_user <= '0;
    else if (out_valid && out_ready)
      exp_user <= (exp_user == USER_W'(NUM_USERS - 1)) ? '0 : exp_user + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (!out_valid && in_ready)); // R1
  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mu == '0) |-> (out_rho2 == '0)); // R5
  AST_NU_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nu2 >= NU_W'(NU_FLOOR))); // R4
  AST_USER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_user == exp_user)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_user) && $stable(out_mu)
                                   && $stable(out_nu2) && $stable(out_rho2))); // R7
  AST_INPUT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R8
endmodule

bind sinr_est sinr_est_chk #(
  .NUM_USERS(NUM_USERS), .USER_W(USER_W), .ACC_W(ACC_W),
  .NU_W(NU_W), .RHO_W(RHO_W), .NU_FLOOR(NU_FLOOR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_user(out_user), .out_mu(out_mu),
  .out_nu2(out_nu2), .out_rho2(out_rho2)
);

// File: tb/tb_sinr_est.sv
`timescale 1ns/1ps
module tb_sinr_est;
  localparam int NU    = 3;
  localparam int UW    = 2;
  localparam int ACC_W = 19;
  localparam int NU_W  = 46;
  localparam int RHO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [UW-1:0] in_user = '0;
  logic [11:0] in_g = '0, in_dinv = '0;
  logic [7:0]  es = 8'd1;
  logic [15:0] recip_len = 16'd1;
  logic in_ready, out_valid;
  logic [UW-1:0]    out_user;
  logic [ACC_W-1:0] out_mu;
  logic [NU_W-1:0]  out_nu2;
  logic [RHO_W-1:0] out_rho2;

  always #2 clk = ~clk;  // 250 MHz

  sinr_est dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_user(in_user), .in_g(in_g), .in_dinv(in_dinv), .in_last(in_last),
    .es(es), .recip_len(recip_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_user(out_user), .out_mu(out_mu), .out_nu2(out_nu2), .out_rho2(out_rho2)
  );

  typedef struct {
    logic [UW-1:0]    user;
    logic [ACC_W-1:0] mu;
    logic [NU_W-1:0]  nu2;
    logic [RHO_W-1:0] rho;
  } item_t;

  item_t exp_q[$];
  int n_tests = 0, n_fail = 0;
  bit finished = 0, running = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected result for one user, straight from R2..R5
  function automatic item_t model(input int u, input logic [127:0] s,
                                  input logic [127:0] rl, input logic [127:0] e);
    item_t it;
    logic [127:0] mu, sq, a, b, nu, rho;
    mu = (s * rl) >> 16;
    sq = mu * mu;
    a  = e * s;
    b  = e * sq;
    nu = (a > b && (a - b) >= 1) ? (a - b) : 128'd1;
    rho = (sq << 4) / nu;
    if (rho > 128'd65535) rho = 128'd65535;
    it.user = UW'(u);
    it.mu   = ACC_W'(mu);
    it.nu2  = NU_W'(nu);
    it.rho  = RHO_W'(rho);
    return it;
  endfunction

  task automatic send_beat(input int u, input int g, input int d, input bit last);
    @(negedge clk);
    repeat ($urandom % 2) @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_user  = UW'(u);
    in_g     = 12'(g);
    in_dinv  = 12'(d);
    in_last  = last;
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  // mode 0: small gains, 1: large gains (floor/saturation), 2: user 0 plus unused index 3
  task automatic run_block(input int len, input int es_v, input int mode);
    logic [127:0] sums [4];
    int bu[$], bg[$], bd[$];
    int rl;
    while (!(exp_q.size() == 0 && in_ready)) @(negedge clk);
    rl = 65536 / len;
    if (rl > 65535) rl = 65535;
    es = 8'(es_v);
    recip_len = 16'(rl);
    for (int k = 0; k < 4; k++) sums[k] = '0;
    for (int t = 0; t < len; t++) begin
      for (int u = 0; u < 4; u++) begin
        int g, d;
        if (mode == 2 && (u == 1 || u == 2)) continue;
        if (mode != 2 && u == 3) continue;
        if (mode == 1 || u == 3) begin
          g = 2000 + int'($urandom % 2000);
          d = 2048 + int'($urandom % 2000);
        end else begin
          g = int'($urandom % 16);
          d = int'($urandom % 4096);
        end
        bu.push_back(u); bg.push_back(g); bd.push_back(d);
        sums[u] = sums[u] + ((g * d) >> 12);  // R2 term; index 3 never reported (R3)
      end
    end
    for (int u = 0; u < NU; u++) exp_q.push_back(model(u, sums[u], rl, es_v));
    for (int k = 0; k < bu.size(); k++)
      send_beat(bu[k], bg[k], bd[k], k == bu.size() - 1);
  endtask

  // Scoreboard monitor
  item_t held;
  bit hold_pending = 0;
  always @(negedge clk) begin
    if (running) begin
      if (hold_pending) begin
        chk("R7", "valid held", 64'(out_valid), 64'd1);
        chk("R7", "held mu", 64'(out_mu), 64'(held.mu));
        chk("R7", "held rho2", 64'(out_rho2), 64'(held.rho));
        hold_pending = 0;
      end
      out_ready = (($urandom % 3) != 0);
      if (out_valid) begin
        if (out_ready) begin
          chk("R8", "in_ready while emitting", 64'(in_ready), 64'd0);
          if (exp_q.size() == 0) begin
            chk("R6", "unexpected result", 64'(out_user), 64'hFFFF);
          end else begin
            item_t e;
            e = exp_q.pop_front();
            chk("R6", "user", 64'(out_user), 64'(e.user));
            chk("R2 R3", "mu", 64'(out_mu), 64'(e.mu));
            chk("R4", "nu2", 64'(out_nu2), 64'(e.nu2));
            chk("R5", "rho2", 64'(out_rho2), 64'(e.rho));
          end
        end else begin
          held.mu = out_mu;
          held.rho = out_rho2;
          hold_pending = 1;
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk("R1", "in_ready after reset", 64'(in_ready), 64'd1);
    running = 1;
    run_block(16, 1, 0);
    run_block(16, 3, 0);
    run_block(8, 2, 1);   // R4 floor, R5 saturation
    run_block(4, 5, 2);   // R3 clear and ignored index
    run_block(1, 1, 0);   // single subcarrier, recip capped
    for (int k = 0; k < 6; k++)
      run_block(1 + int'($urandom % 20), 1 + int'($urandom % 20), k % 3);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule